// File: doc/BRIEF.md
# Fuse Macro Auto-Read Sequencer

This block fetches one 32-bit word from a one-time-programmable fuse array without software toggling the array's pins. Software places a 10-bit word address together with an enable bit and a read-command bit into the auto-control register. The block then runs a counter from zero and, on every cycle, works out the level of each macro pin from a per-pin window: an assert cycle and a release cycle held in that pin's read-timing register. The whole read waveform is therefore set by software rather than fixed in the state machine.

The data output of the macro is sampled on the last cycle the strobe is high and placed in a result register, and a sticky finish flag is raised when the counter reaches the end of the longest window. Every timing register comes out of reset holding a working read waveform, so a read works before any timing has been programmed. A second bank of five program-timing registers is stored and read back for a separate programming engine; it has no effect here. The program-enable pin is never driven to its program level.

Register offsets (byte addresses on the word bus): 0x00 mode, 0x18 status, 0x20 result, 0x24 auto-control, 0x28/0x2C/0x30/0x34/0x38 program timing and 0x3C/0x40/0x44/0x48/0x4C read timing, both banks ordered chip-select, program-enable, load, address, strobe.

Top module: `fuse_autoread_ctrl`

## Requirements
- R1: After reset the chip-select output is high (inactive), load and strobe are low, the address output is zero, the finish flag reads 0, and every timing register reads its default: chip-select, program-enable and load windows 0..11, address 2..10, strobe 5..8 (assert cycle in bits 31:16, release cycle in bits 15:0).
- R2: A write to 0x24 with bit 0 (enable) and bit 1 (read) both set, while idle and with mode bit 0 at 0x00 clear, starts a read of the fuse word whose address is in bits 25:16; bits 25:16 and bit 0 read back, bit 1 reads 1 while the read runs.
- R3: With mode bit 0 at 0x00 set (manual mode), a read command starts nothing: the pins stay idle and the finish flag stays 0. A command with the read bit set but the enable bit clear also starts nothing.
- R4: During a read, with count k = cycles since the command edge, a pin is active when assert <= k < release of its read-timing register; chip-select is active low, load and strobe active high, and the address output carries the word address while active and zero otherwise.
- R5: A read lasts for the largest release cycle of the five read-timing registers (at least one cycle); the finish flag is visible on the cycle after the last one, and bit 1 of 0x24 reads 0 from then on.
- R6: The macro data is captured on the last cycle the strobe is high (k = strobe release - 1) and is readable at 0x20 after the read.
- R7: The finish flag is bit 0 of 0x18; writing 1 clears it, writing 0 leaves it set.
- R8: A write to 0x24 during a read is ignored: address and enable read back unchanged, the running read completes with the original address, and no second read follows.
- R9: The program-enable output is held high (non-program level) at all times.
- R10: All ten timing registers are writable and read back what was written; the program-timing bank at 0x28..0x38 has no effect on the read waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, with bus_req_i |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| fuse_csb_o | output | 1 | Macro chip select, active low |
| fuse_pgenb_o | output | 1 | Macro program enable, active low, held high |
| fuse_load_o | output | 1 | Macro load enable |
| fuse_strobe_o | output | 1 | Macro read strobe |
| fuse_addr_o | output | 10 | Macro word address |
| fuse_dout_i | input | 32 | Macro data output |

## Verification
The assertions take for granted that the bus only writes whole registers at word-aligned offsets and that the fuse data input is meaningful only while the strobe window overlaps the address window, so the capture check looks at when the result changes rather than at its value. The bench keeps to this by using only aligned offsets, by programming timing sets whose strobe lies inside the address and chip-select windows, and by a macro stub that returns an address-dependent word only while chip-select, load and strobe are all active and a garbage constant otherwise, so a capture on the wrong cycle shows up as a data mismatch.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  localparam int NPINS = 5;
  localparam int TIM_W = 16;
  localparam int NREGS = 2 * NPINS;
  localparam int IDX_W = $clog2(NREGS);

  // pin order is shared by both timing banks and the register offsets
  localparam int PIN_CS   = 0;
  localparam int PIN_PGM  = 1;
  localparam int PIN_LOAD = 2;
  localparam int PIN_ADDR = 3;
  localparam int PIN_STRB = 4;

  typedef struct packed {
    logic [TIM_W-1:0] on_cyc;
    logic [TIM_W-1:0] off_cyc;
  } win_t;

  function automatic win_t rd_default(int pin);
    win_t w;
    case (pin)
      PIN_ADDR: begin w.on_cyc = 16'd2; w.off_cyc = 16'd10; end
      PIN_STRB: begin w.on_cyc = 16'd5; w.off_cyc = 16'd8;  end
      default:  begin w.on_cyc = 16'd0; w.off_cyc = 16'd11; end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/fuse_timing_bank.sv
module fuse_timing_bank
  import fuse_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  win_t             wr_data_i,
  output win_t             regs_o [NREGS]
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    win_t reg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  reg_q <= rd_default(g % NPINS);
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    reg_q <= wr_data_i;
    end
    assign regs_o[g] = reg_q;
  end
endmodule

// File: rtl/fuse_pin_window.sv
module fuse_pin_window
  import fuse_seq_pkg::*;
(
  input  logic             busy_i,
  input  logic [TIM_W-1:0] cnt_i,
  input  win_t             win_i,
  output logic             act_o
);
  assign act_o = busy_i && (cnt_i >= win_i.on_cyc) && (cnt_i < win_i.off_cyc);
endmodule

// File: rtl/fuse_seq_core.sv
module fuse_seq_core
  import fuse_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  win_t              rd_win_i [NPINS],
  input  logic [DATA_W-1:0] fuse_dout_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [NPINS-1:0]  act_o,
  output logic [DATA_W-1:0] data_o
);
  logic [TIM_W-1:0]  cnt_q, len, last;
  logic              busy_q;
  logic [DATA_W-1:0] data_q;
  logic              cap;

  always_comb begin
    len = '0;
    for (int i = 0; i < NPINS; i++)
      if (rd_win_i[i].off_cyc > len) len = rd_win_i[i].off_cyc;
    last = (len == '0) ? '0 : len - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == last) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_win
    fuse_pin_window u_win (
      .busy_i (busy_q),
      .cnt_i  (cnt_q),
      .win_i  (rd_win_i[g]),
      .act_o  (act_o[g])
    );
  end

  // sample on the last strobe-high cycle
  assign cap = busy_q && rd_win_i[PIN_STRB].off_cyc != '0 &&
               cnt_q == rd_win_i[PIN_STRB].off_cyc - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  data_q <= '0;
    else if (cap) data_q <= fuse_dout_i;
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && cnt_q == last;
  assign data_o = data_q;

  assert_len_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= last));
  assert_capture_in_seq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_q) |-> $past(busy_q));
endmodule

// File: rtl/fuse_autoread_ctrl.sv
module fuse_autoread_ctrl
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              fuse_csb_o,
  output logic              fuse_pgenb_o,
  output logic              fuse_load_o,
  output logic              fuse_strobe_o,
  output logic [ADDR_W-1:0] fuse_addr_o,
  input  logic [DATA_W-1:0] fuse_dout_i
);
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h18;
  localparam logic [7:0] OFS_DATA = 8'h20;
  localparam logic [7:0] OFS_AUTO = 8'h24;
  localparam logic [7:0] OFS_TIM0 = 8'h28;
  localparam logic [7:0] OFS_TIMN = OFS_TIM0 + 8'(4 * (NREGS - 1));
  localparam int         A_LSB    = 16;

  logic              wr, wr_auto, start, busy, done;
  logic              manual_q, auto_en_q, finish_q;
  logic [ADDR_W-1:0] faddr_q;
  logic [NPINS-1:0]  act;
  logic [DATA_W-1:0] data;
  logic              tim_hit;
  logic [7:0]        tim_ofs;
  logic [IDX_W-1:0]  tim_idx;
  win_t              regs [NREGS];
  win_t              rd_win [NPINS];
  logic              unused_pgm_win;

  assign wr      = bus_req_i && bus_we_i;
  assign wr_auto = wr && bus_addr_i == OFS_AUTO;
  assign start   = wr_auto && !busy && !manual_q && bus_wdata_i[0] && bus_wdata_i[1];
  assign tim_ofs = bus_addr_i - OFS_TIM0;
  assign tim_idx = tim_ofs[IDX_W+1:2];
  assign tim_hit = bus_addr_i >= OFS_TIM0 && bus_addr_i <= OFS_TIMN && bus_addr_i[1:0] == 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      manual_q  <= 1'b0;
      auto_en_q <= 1'b0;
      faddr_q   <= '0;
      finish_q  <= 1'b0;
    end else begin
      if (wr && bus_addr_i == OFS_MODE) manual_q <= bus_wdata_i[0];
      if (wr_auto && !busy) begin
        auto_en_q <= bus_wdata_i[0];
        faddr_q   <= bus_wdata_i[A_LSB +: ADDR_W];
      end
      if (done) finish_q <= 1'b1;
      else if (wr && bus_addr_i == OFS_STAT && bus_wdata_i[0]) finish_q <= 1'b0;
    end
  end

  fuse_timing_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr && tim_hit),
    .wr_idx_i  (tim_idx),
    .wr_data_i (bus_wdata_i),
    .regs_o    (regs)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_rd
    assign rd_win[g] = regs[NPINS + g];
  end

  fuse_seq_core #(.DATA_W(DATA_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .rd_win_i    (rd_win),
    .fuse_dout_i (fuse_dout_i),
    .busy_o      (busy),
    .done_o      (done),
    .act_o       (act),
    .data_o      (data)
  );

  // program-enable window only stretches the sequence; the pin never programs
  assign unused_pgm_win = act[PIN_PGM];
  assign fuse_csb_o     = !act[PIN_CS];
  assign fuse_pgenb_o   = 1'b1;
  assign fuse_load_o    = act[PIN_LOAD];
  assign fuse_strobe_o  = act[PIN_STRB];
  assign fuse_addr_o    = act[PIN_ADDR] ? faddr_q : '0;

  always_comb begin
    bus_rdata_o = '0;
    if (tim_hit) bus_rdata_o = regs[tim_idx];
    else case (bus_addr_i)
      OFS_MODE: bus_rdata_o[0] = manual_q;
      OFS_STAT: bus_rdata_o[0] = finish_q;
      OFS_DATA: bus_rdata_o    = 32'(data);
      OFS_AUTO: begin
        bus_rdata_o[A_LSB +: ADDR_W] = faddr_q;
        bus_rdata_o[1]               = busy;
        bus_rdata_o[0]               = auto_en_q;
      end
      default:  bus_rdata_o = '0;
    endcase
  end

  assert_idle_pins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (fuse_csb_o && !fuse_load_o && !fuse_strobe_o && fuse_addr_o == '0));
  assert_finish_after_seq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(finish_q) |-> $past(busy));
  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_auto) |=> $stable(faddr_q));
  assert_manual_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (manual_q && !busy) |=> !busy);
endmodule

// File: tb/tb_fuse_autoread_ctrl.sv
module tb_fuse_autoread_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        fuse_csb_o, fuse_pgenb_o, fuse_load_o, fuse_strobe_o;
  logic [9:0]  fuse_addr_o;
  logic [31:0] fuse_dout_i;

  int checks = 0, fails = 0;
  int es [5], ee [5];   // expected read-timing windows
  int ps [5], pe [5];   // expected program-timing windows

  always #5 clk = ~clk;

  fuse_autoread_ctrl dut (.*, .clk_i(clk));

  function automatic logic [31:0] stub_word(logic [9:0] a);
    return {6'h2B, a, 6'h15, ~a};
  endfunction

  // behavioural macro: valid word only while selected, loaded and strobed
  assign fuse_dout_i = (!fuse_csb_o && fuse_load_o && fuse_strobe_o) ?
                       stub_word(fuse_addr_o) : 32'hBAD0_BAD0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  function automatic int seq_len();
    int m = 0;
    for (int i = 0; i < 5; i++) if (ee[i] > m) m = ee[i];
    return (m == 0) ? 1 : m;
  endfunction

  // starts a read and checks every pin on every cycle, then finish and data
  task automatic run_read(logic [9:0] a, string tag);
    logic [31:0] r;
    int bad = 0, len = seq_len();
    logic [31:0] first_bad = '0, first_exp = '0;
    bus_write(8'h24, {6'd0, a, 14'd0, 2'b11});
    bus_read(8'h24, r);
    check(r[1] == 1'b1 && r[25:16] == a && r[0], {"R2 busy/addr readback ", tag}, r, {6'd0, a, 14'd0, 2'b11});
    for (int k = 0; k < len; k++) begin
      logic [13:0] got, exp;
      if (k > 0) @(negedge clk);
      #1;
      got = {fuse_csb_o, fuse_pgenb_o, fuse_load_o, fuse_strobe_o, fuse_addr_o};
      exp = {!(k >= es[0] && k < ee[0]), 1'b1, (k >= es[2] && k < ee[2]),
             (k >= es[4] && k < ee[4]), ((k >= es[3] && k < ee[3]) ? a : 10'd0)};
      if (got != exp && bad == 0) begin first_bad = 32'(got); first_exp = 32'(exp); end
      if (got != exp) bad++;
      if (k == len - 1) begin
        bus_read(8'h18, r);
        check(r[0] == 1'b0, {"R5 finish not early ", tag}, r, 0);
      end
    end
    check(bad == 0, {"R4 R9 pin waveform ", tag}, first_bad, first_exp);
    @(negedge clk);
    bus_read(8'h18, r);
    check(r[0] == 1'b1, {"R5 finish after length ", tag}, r, 1);
    bus_read(8'h24, r);
    check(r[1] == 1'b0, {"R5 read bit self-clears ", tag}, r, 0);
    bus_read(8'h20, r);
    check(r == stub_word(a), {"R6 captured data ", tag}, r, stub_word(a));
  endtask

  task automatic clear_finish();
    bus_write(8'h18, 32'h1);
  endtask

  task automatic set_timing(int idx, int s, int e);
    bus_write(8'(8'h28 + 4 * idx), {16'(s), 16'(e)});
    if (idx >= 5) begin es[idx-5] = s; ee[idx-5] = e; end
    else begin ps[idx] = s; pe[idx] = e; end
  endtask

  task automatic t_reset();
    logic [31:0] r;
    #1;
    check(fuse_csb_o && fuse_pgenb_o && !fuse_load_o && !fuse_strobe_o && fuse_addr_o == 0,
          "R1 idle pins", {fuse_csb_o, fuse_pgenb_o, fuse_load_o, fuse_strobe_o}, 32'hC);
    bus_read(8'h18, r);
    check(r == 0, "R1 finish clear", r, 0);
    for (int i = 0; i < 10; i++) begin
      int p = i % 5;
      int s = (p == 3) ? 2 : (p == 4) ? 5 : 0;
      int e = (p == 3) ? 10 : (p == 4) ? 8 : 11;
      bus_read(8'(8'h28 + 4 * i), r);
      check(r == {16'(s), 16'(e)}, "R1 timing default", r, {16'(s), 16'(e)});
      if (i >= 5) begin es[p] = s; ee[p] = e; end else begin ps[p] = s; pe[p] = e; end
    end
  endtask

  task automatic t_w1c();
    logic [31:0] r;
    bus_write(8'h18, 32'h0);
    bus_read(8'h18, r);
    check(r[0] == 1'b1, "R7 write 0 keeps finish", r, 1);
    clear_finish();
    bus_read(8'h18, r);
    check(r[0] == 1'b0, "R7 write 1 clears finish", r, 0);
  endtask

  task automatic t_no_start(logic [31:0] mode, logic [31:0] cmd, string tag);
    logic [31:0] r;
    int bad = 0;
    bus_write(8'h00, mode);
    bus_write(8'h24, cmd);
    for (int k = 0; k < 20; k++) begin
      #1;
      if (!fuse_csb_o || fuse_load_o || fuse_strobe_o) bad++;
      @(negedge clk);
    end
    check(bad == 0, {"R3 pins idle ", tag}, 32'(bad), 0);
    bus_read(8'h18, r);
    check(r[0] == 1'b0, {"R3 no finish ", tag}, r, 0);
    bus_write(8'h00, 32'h0);
  endtask

  task automatic t_busy_write();
    logic [31:0] r;
    logic [9:0] a = 10'h0A5, b = 10'h35A;
    bus_write(8'h24, {6'd0, a, 14'd0, 2'b11});
    repeat (3) @(negedge clk);
    bus_write(8'h24, {6'd0, b, 14'd0, 2'b10});
    bus_read(8'h24, r);
    check(r[25:16] == a && r[0] == 1'b1, "R8 auto reg unchanged", r, {6'd0, a, 16'd3});
    repeat (12) @(negedge clk);
    bus_read(8'h20, r);
    check(r == stub_word(a), "R8 original address read", r, stub_word(a));
    clear_finish();
    repeat (15) @(negedge clk);
    bus_read(8'h18, r);
    check(r[0] == 1'b0, "R8 no second read", r, 0);
  endtask

  task automatic t_prog_bank();
    logic [31:0] r;
    for (int i = 0; i < 5; i++) set_timing(i, 3 + i, 40 + i);
    for (int i = 0; i < 5; i++) begin
      bus_read(8'(8'h28 + 4 * i), r);
      check(r == {16'(ps[i]), 16'(pe[i])}, "R10 program timing readback", r, {16'(ps[i]), 16'(pe[i])});
    end
    run_read(10'h111, "program bank ignored R10");
    clear_finish();
  endtask

  task automatic t_custom();
    logic [31:0] r;
    set_timing(5, 0, 7);
    set_timing(6, 0, 5);
    set_timing(7, 0, 7);
    set_timing(8, 1, 6);
    set_timing(9, 2, 4);
    bus_read(8'h4C, r);
    check(r == 32'h0002_0004, "R10 read timing readback", r, 32'h0002_0004);
    run_read(10'h2C3, "custom R4");
    clear_finish();
    set_timing(6, 0, 14);   // longest window now on program-enable
    run_read(10'h3FF, "longest on pgm R5");
    clear_finish();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    run_read(10'h155, "typical R2");
    t_w1c();
    t_no_start(32'h1, {6'd0, 10'h077, 14'd0, 2'b11}, "manual mode");
    t_no_start(32'h0, {6'd0, 10'h077, 14'd0, 2'b10}, "enable clear");
    t_busy_write();
    t_prog_bank();
    t_custom();
    run_read(10'h000, "address zero R2");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule